// File: doc/BRIEF.md
# Vector Byte Shuffle Unit

This block rearranges the bytes of two 128-bit source vectors into one 128-bit result. A third 128-bit control vector supplies one control byte per result byte. Each control byte does one of two things. It can pick any of the 32 bytes in the joined pair of sources. It can also plant a fixed constant byte in that position. Typical uses are inserting elements into vectors, packing and unpacking, and small table lookups done in a single pass.

The 16 result lanes are computed side by side, and no lane depends on another. The permuted vector is captured in a single register stage. Two states control this stage. In `ST_EMPTY` the register holds nothing. In `ST_FULL` it holds a result that the consumer has not yet taken.

The state transitions are:
- `ST_EMPTY` to `ST_FULL` when an input is accepted.
- `ST_FULL` to `ST_FULL` on a stall, or when a new input replaces the result as it is taken.
- `ST_FULL` to `ST_EMPTY` when the result is taken and no new input arrives.

Top module: `vshuf_unit`

## Requirements
- R1: Right after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Each result byte depends only on the control byte in the same lane and on the sources. Changing one lane's control byte leaves every other result byte unchanged.
- R3: A control byte whose bits [7:6] equal `2'b10` makes that result byte `8'h00`.
- R4: A control byte whose bits [7:5] equal `3'b110` makes that result byte `8'hFF`.
- R5: A control byte whose bits [7:5] equal `3'b111` makes that result byte `8'h80`.
- R6: A control byte with bit 7 equal to 0 uses its bits [4:0] as an index `k` into `{src_a, src_b}`. Byte `k` of that concatenation is bits [255-8k -: 8]: index 0 is the most significant byte of `src_a`, and index 31 is the least significant byte of `src_b`. Result lane `j` is `result[127-8j -: 8]` and is controlled by `pattern[127-8j -: 8]`.
- R7: When bit 7 of a control byte is 0, bits 6 and 5 have no effect on the result.
- R8: An input is accepted when `in_valid` and `in_ready` are both high at a rising edge. After that edge, `out_valid` is 1 and `result` holds the permutation of that input.
- R9: While `out_valid` is 1 and `out_ready` is 0, `result` and `out_valid` stay unchanged and `in_ready` is 0.
- R10: `in_ready` is 1 whenever `out_ready` is 1, so back-to-back inputs are accepted at one per cycle. When the result is taken and no input is accepted, `out_valid` drops to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operands are present |
| in_ready | output | 1 | Unit can take the operands this cycle |
| src_a | input | 128 | First source vector (concatenation bytes 0..15) |
| src_b | input | 128 | Second source vector (concatenation bytes 16..31) |
| pattern | input | 128 | One control byte per result lane |
| out_valid | output | 1 | Result register holds an untaken result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 128 | Permuted vector |

## Verification
The bench sweeps every control-byte value through every lane, so the boundaries between the constant codes and the index path are all exercised.

Specific failure modes the checks target:
- A decoder that tests bit 5 before bit 6, or that lets `2'b10` fall through to indexing, plants the wrong constant or a source byte.
- A decoder that reads bits 6 and 5 on the index path fails the aliasing cases.
- A mux with reversed byte numbering swaps index 0 with index 31.

The handshake is driven through back-to-back acceptance and a multi-cycle stall with new input waiting. A stage that overwrites under backpressure, or one that drops `in_ready` while the consumer is draining, produces a wrong or missing result.

// File: rtl/vshuf_pkg.sv
package vshuf_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        KIND_ZERO,
        KIND_ONES,
        KIND_SIGN,
        KIND_PICK
    } lane_kind_e;

    typedef enum logic {
        ST_EMPTY,
        ST_FULL
    } stage_state_e;
endpackage

// File: rtl/vshuf_decode.sv
module vshuf_decode
    import vshuf_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic [BYTE_W-1:0] ctl,
    output lane_kind_e        kind,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        unique casez (ctl[7:5])
            3'b0??:  kind = KIND_PICK;
            3'b10?:  kind = KIND_ZERO;
            3'b110:  kind = KIND_ONES;
            3'b111:  kind = KIND_SIGN;
            default: kind = KIND_PICK;
        endcase
        idx = ctl[IDX_W-1:0];
    end
endmodule

// File: rtl/vshuf_lane.sv
module vshuf_lane
    import vshuf_pkg::*;
#(
    parameter int unsigned SRC_BYTES = 32,
    parameter int unsigned IDX_W     = 5
) (
    input  logic [SRC_BYTES*BYTE_W-1:0] pool,
    input  logic [BYTE_W-1:0]           ctl,
    output logic [BYTE_W-1:0]           lane_out
);
    lane_kind_e        kind;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] picked;

    vshuf_decode #(.IDX_W(IDX_W)) dec_i (
        .ctl  (ctl),
        .kind (kind),
        .idx  (idx)
    );

    always_comb begin
        picked = '0;
        for (int k = 0; k < SRC_BYTES; k++) begin
            if (idx == IDX_W'(k)) begin
                picked = pool[(SRC_BYTES-1-k)*BYTE_W +: BYTE_W];
            end
        end
    end

    always_comb begin
        unique case (kind)
            KIND_ZERO: lane_out = 8'h00;
            KIND_ONES: lane_out = 8'hFF;
            KIND_SIGN: lane_out = 8'h80;
            default:   lane_out = picked;
        endcase
    end
endmodule

// File: rtl/vshuf_unit.sv
module vshuf_unit
    import vshuf_pkg::*;
#(
    parameter int unsigned LANES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*BYTE_W-1:0] src_a,
    input  logic [LANES*BYTE_W-1:0] src_b,
    input  logic [LANES*BYTE_W-1:0] pattern,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*BYTE_W-1:0] result
);
    localparam int unsigned VEC_W     = LANES * BYTE_W;
    localparam int unsigned SRC_BYTES = 2 * LANES;
    localparam int unsigned IDX_W     = $clog2(SRC_BYTES);

    stage_state_e           state_q, state_d;
    logic [2*VEC_W-1:0]     pool;
    logic [VEC_W-1:0]       shuffled;
    logic [VEC_W-1:0]       result_q;
    logic                   accept;

    assign pool = {src_a, src_b};

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        vshuf_lane #(.SRC_BYTES(SRC_BYTES), .IDX_W(IDX_W)) lane_i (
            .pool     (pool),
            .ctl      (pattern[VEC_W-1-j*BYTE_W -: BYTE_W]),
            .lane_out (shuffled[VEC_W-1-j*BYTE_W -: BYTE_W])
        );
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !accept) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_EMPTY: begin out_valid = 1'b0; in_ready = 1'b1;      end
            ST_FULL:  begin out_valid = 1'b1; in_ready = out_ready; end
            default:  begin out_valid = 1'b0; in_ready = 1'b0;      end
        endcase
        accept = in_valid && in_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      result_q <= '0;
        else if (accept) result_q <= shuffled;
    end

    assign result = result_q;
endmodule

// File: rtl/vshuf_unit_chk.sv
module vshuf_unit_chk #(
    parameter int unsigned LANES = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic [LANES*8-1:0]   pattern,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [LANES*8-1:0]   result
);
    localparam int unsigned VEC_W = LANES * 8;
    logic acc;
    assign acc = in_valid && in_ready;

    assert_valid_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(result)));
    assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    assert_drain_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);
    assert_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pattern[VEC_W-1 -: 2] == 2'b10) |=> result[VEC_W-1 -: 8] == 8'h00);
    assert_ones_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pattern[VEC_W-1 -: 3] == 3'b110) |=> result[VEC_W-1 -: 8] == 8'hFF);
    assert_sign_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pattern[VEC_W-1 -: 3] == 3'b111) |=> result[VEC_W-1 -: 8] == 8'h80);
endmodule

bind vshuf_unit vshuf_unit_chk #(.LANES(LANES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .pattern   (pattern),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .result    (result)
);

// File: tb/vshuf_unit_tb_top.sv
`timescale 1ns/1ps
module vshuf_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] pattern = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] result;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    vshuf_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src_a(src_a), .src_b(src_b), .pattern(pattern),
        .out_valid(out_valid), .out_ready(out_ready), .result(result)
    );

    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input logic [127:0] p);
        logic [255:0] cat;
        logic [7:0]   pb;
        logic [127:0] r;
        cat = {a, b};
        r = '0;
        for (int j = 0; j < 16; j++) begin
            pb = p[127-8*j -: 8];
            if (pb[7:6] == 2'b10)       r[127-8*j -: 8] = 8'h00;
            else if (pb[7:5] == 3'b110) r[127-8*j -: 8] = 8'hFF;
            else if (pb[7:5] == 3'b111) r[127-8*j -: 8] = 8'h80;
            else                        r[127-8*j -: 8] = cat[255-8*int'(pb[4:0]) -: 8];
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [7:0] pb);
        if (pb[7:6] == 2'b10)       return "R3";
        else if (pb[7:5] == 3'b110) return "R4";
        else if (pb[7:5] == 3'b111) return "R5";
        else                        return "R6";
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic check_vec(input string req, input logic [127:0] exp, input logic [127:0] p);
        n_checks++;
        if (result !== exp || out_valid !== 1'b1) begin
            n_errors++;
            for (int j = 0; j < 16; j++) begin
                if (result[127-8*j -: 8] !== exp[127-8*j -: 8]) begin
                    $display("FAIL %s/%s lane %0d ctl=%h: actual=%h expected=%h (valid=%0b)",
                             req, tag_of(p[127-8*j -: 8]), j, p[127-8*j -: 8],
                             result, exp, out_valid);
                    break;
                end
            end
            if (result === exp)
                $display("FAIL %s: actual out_valid=%0b expected=1", req, out_valid);
        end
    endtask

    task automatic one_shot(input string req, input logic [127:0] a, input logic [127:0] b,
                            input logic [127:0] p);
        @(negedge clk);
        src_a = a; src_b = b; pattern = p; in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_vec(req, model(a, b, p), p);
    endtask

    function automatic logic [127:0] mk_src(input int base);
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[127-8*i -: 8] = 8'(base + 5*i);
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        logic [127:0] a1, b1, p1, p2, base_r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 out_valid", out_valid, 1'b0);
        check_bit("R1 in_ready", in_ready, 1'b1);

        // Sweep: every control value in every lane (R3 R4 R5 R6)
        for (int v = 0; v < 256; v++) begin
            logic [127:0] p;
            for (int j = 0; j < 16; j++) p[127-8*j -: 8] = 8'(v + 37*j);
            one_shot("R2", mk_src(v), mk_src(v + 80), p);
        end

        // R7: bits 6 and 5 ignored on index path
        a1 = mk_src(1); b1 = mk_src(81);
        for (int s = 0; s < 4; s++) begin
            logic [127:0] p;
            for (int j = 0; j < 16; j++) p[127-8*j -: 8] = {1'b0, 2'(s), 5'(31 - 2*j)};
            one_shot("R7", a1, b1, p);
            n_checks++;
            for (int j = 0; j < 16; j++)
                if (result[127-8*j -: 8] !== model(a1, b1, {16{8'(31 - 2*j)}})[127-8*j -: 8]) begin
                    n_errors++;
                    $display("FAIL R7 lane %0d: actual=%h expected=%h", j,
                             result[127-8*j -: 8], model(a1, b1, {16{8'(31 - 2*j)}})[127-8*j -: 8]);
                    break;
                end
        end

        // R2: change one lane only
        p1 = {16{8'h07}};
        one_shot("R2", a1, b1, p1);
        base_r = result;
        p2 = p1; p2[127-8*5 -: 8] = 8'hC0;
        one_shot("R2", a1, b1, p2);
        n_checks++;
        if ((result ^ base_r) !== (128'hFF << (8*10)) & (result ^ base_r)
            || result[127-8*5 -: 8] !== 8'hFF) begin
            n_errors++;
            $display("FAIL R2: actual=%h expected only lane 5 changed from %h", result, base_r);
        end

        // R10: back-to-back
        @(negedge clk);
        out_ready = 1'b1; src_a = a1; src_b = b1; pattern = p1; in_valid = 1'b1;
        @(negedge clk);
        check_vec("R10", model(a1, b1, p1), p1);
        check_bit("R10 in_ready", in_ready, 1'b1);
        pattern = p2;
        @(negedge clk);
        in_valid = 1'b0;
        check_vec("R10", model(a1, b1, p2), p2);
        @(negedge clk);
        check_bit("R10 drain", out_valid, 1'b0);

        // R8/R9: stall with pending input
        out_ready = 1'b0; pattern = p1; in_valid = 1'b1;
        @(negedge clk);
        check_vec("R8", model(a1, b1, p1), p1);
        pattern = p2;
        for (int c = 0; c < 3; c++) begin
            check_bit("R9 in_ready", in_ready, 1'b0);
            @(negedge clk);
            check_vec("R9", model(a1, b1, p1), p1);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_vec("R9", model(a1, b1, p2), p2);
        @(negedge clk);
        check_bit("R10 drain", out_valid, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule